// File: doc/BRIEF.md
# Dual Limit-Match Interval Timer

This block holds two identical up-counters that software sets up through an auxiliary register bus. Each timer has a count register, a limit register and a two-bit control register. On every counting cycle the count moves up by one. When the count already equals the limit, the next counting cycle returns it to zero instead, so one programmed limit gives a repeating interval with no software reload. A timer can raise a level interrupt on that match. Software clears the interrupt by writing the timer's control register, with any value.

One control bit lets a timer stop while the host CPU reports that it is halted. Setting the limit to all ones turns a timer into a free-running counter that wraps. A typical setup uses one timer for periodic or one-shot event interrupts and the other as a monotonic timestamp source.

Each timer's interrupt logic is a two-state machine. `IRQ_IDLE` moves to `IRQ_RAISED` on the transition *arm*: a counting cycle where the count equals the limit while interrupt-enable is set and no control write is present. `IRQ_RAISED` moves back to `IRQ_IDLE` on the transition *ack*, which is any control-register write. In `IRQ_IDLE` a control write is also taken as *ack*, and the machine stays idle even if a match happens in that cycle.

Top module: `limit_timer_pair`

## Requirements
- R1: Registers sit at these bus addresses: timer 0 count 0x21, control 0x22, limit 0x23; timer 1 count 0x100, control 0x101, limit 0x102. A read returns the register's current value, zero-extended to the data width. A control read returns bit 0 = interrupt enable and bit 1 = halt gating.
- R2: On each counting cycle the count increases by one.
- R3: On a counting cycle where the count equals the limit, the count becomes 0 at the next edge, and counting then continues.
- R4: If interrupt enable (control bit 0) is 1 and a match occurs, the timer's irq output rises after that edge and stays high until a control write. If enable is 0, a match leaves irq low.
- R5: Every write to a timer's control register clears that timer's irq, whatever value is written. If the write arrives in the same cycle as a match, the clear wins.
- R6: If halt gating (control bit 1) is 1, the count holds in every cycle where cpu_halted is 1. If halt gating is 0, cpu_halted has no effect.
- R7: A count-register write replaces the count in place of that cycle's increment or wrap. Writing 0 restarts the interval.
- R8: With the limit at all ones, the count runs freely and wraps from all ones to 0.
- R9: Reads of any address other than the six mapped ones return 0. Writes to them change no register and no irq.
- R10: The two timers are independent. An access to one never alters the other's count, limit, control or irq.
- R11: Reset gives count 0, control 0, limit all ones and irq low for both timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aux_addr | input | ADDR_W | Register address for both read and write |
| aux_wr | input | 1 | Write strobe for the addressed register |
| aux_wdata | input | DATA_W | Write data |
| cpu_halted | input | 1 | High while the host CPU is halted |
| aux_rdata | output | DATA_W | Combinational read data for aux_addr |
| irq | output | 2 | Interrupt level, bit t for timer t |

## Verification
The bench builds the block with a 6-bit count width, while the address and data widths stay at 12 and 32 bits. With that width, every limit from 0 to 63 can be swept with interrupts enabled, each one over two full intervals. The free-running timer also wraps many times during the run. Because the address is 12 bits, the bench can read every one of the 4096 addresses and can write every unmapped address. A cycle-level model in the bench checks each cycle, including halt patterns, count-write collisions and an acknowledge that lands in a match cycle.

// File: rtl/timer_pair_pkg.sv
package timer_pair_pkg;

    localparam int unsigned N_TIMERS = 2;

    // register offsets from a timer's base address
    localparam int unsigned OFS_COUNT = 0;
    localparam int unsigned OFS_CTRL  = 1;
    localparam int unsigned OFS_LIMIT = 2;

    typedef struct packed {
        logic nh;   // bit 1: count only while CPU not halted
        logic ie;   // bit 0: interrupt on limit match
    } tmr_ctrl_t;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    function automatic int unsigned timer_base(input int unsigned t);
        return (t == 0) ? 32'h21 : 32'h100;
    endfunction

endpackage

// File: rtl/aux_decode.sv
module aux_decode
    import timer_pair_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    output logic [N_TIMERS-1:0] hit_cnt,
    output logic [N_TIMERS-1:0] hit_ctl,
    output logic [N_TIMERS-1:0] hit_lim,
    output logic [N_TIMERS-1:0] we_cnt,
    output logic [N_TIMERS-1:0] we_ctl,
    output logic [N_TIMERS-1:0] we_lim
);

    for (genvar t = 0; t < N_TIMERS; t++) begin : g_dec
        localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(timer_base(t) + OFS_COUNT);
        localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(timer_base(t) + OFS_CTRL);
        localparam logic [ADDR_W-1:0] A_LIM = ADDR_W'(timer_base(t) + OFS_LIMIT);

        assign hit_cnt[t] = (addr == A_CNT);
        assign hit_ctl[t] = (addr == A_CTL);
        assign hit_lim[t] = (addr == A_LIM);
        assign we_cnt[t]  = wr & hit_cnt[t];
        assign we_ctl[t]  = wr & hit_ctl[t];
        assign we_lim[t]  = wr & hit_lim[t];
    end

endmodule

// File: rtl/timer_unit.sv
module timer_unit
    import timer_pair_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_halted,
    input  logic             cnt_we,
    input  logic             ctl_we,
    input  logic             lim_we,
    input  logic [CNT_W-1:0] wr_val,
    input  tmr_ctrl_t        ctl_val,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] limit_o,
    output tmr_ctrl_t        ctrl_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] count_q, count_d;
    logic [CNT_W-1:0] limit_q;
    tmr_ctrl_t        ctrl_q;
    irq_state_e       state_q, state_d;
    logic             tick, hit;

    assign tick = !(ctrl_q.nh && cpu_halted);
    assign hit  = tick && (count_q == limit_q);

    always_comb begin
        if (cnt_we)      count_d = wr_val;
        else if (hit)    count_d = '0;
        else if (tick)   count_d = count_q + 1'b1;
        else             count_d = count_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            limit_q <= '1;
            ctrl_q  <= '0;
        end else begin
            count_q <= count_d;
            if (lim_we) limit_q <= wr_val;
            if (ctl_we) ctrl_q  <= ctl_val;
        end
    end

    // interrupt state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (!ctl_we && hit && ctrl_q.ie) state_d = IRQ_RAISED;
            IRQ_RAISED: if (ctl_we)                      state_d = IRQ_IDLE;
            default:                                     state_d = IRQ_IDLE;
        endcase
    end

    // interrupt state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    // interrupt state machine: outputs
    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

    assign count_o = count_q;
    assign limit_o = limit_q;
    assign ctrl_o  = ctrl_q;

    a_r4_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ctl_we) |=> irq_o);

    a_r4_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !ctrl_q.ie) |=> !irq_o);

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> !irq_o);

    a_r6_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.nh && cpu_halted && !cnt_we) |=> $stable(count_o));

    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_o == limit_o && !cnt_we) |=> (count_o == '0));

    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (count_o == $past(wr_val)));

endmodule

// File: rtl/limit_timer_pair.sv
module limit_timer_pair
    import timer_pair_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   aux_addr,
    input  logic                aux_wr,
    input  logic [DATA_W-1:0]   aux_wdata,
    input  logic                cpu_halted,
    output logic [DATA_W-1:0]   aux_rdata,
    output logic [N_TIMERS-1:0] irq
);

    localparam int unsigned CTL_W = $bits(tmr_ctrl_t);

    logic [N_TIMERS-1:0] hit_cnt, hit_ctl, hit_lim;
    logic [N_TIMERS-1:0] we_cnt, we_ctl, we_lim;
    logic [CNT_W-1:0]    count_arr [N_TIMERS];
    logic [CNT_W-1:0]    limit_arr [N_TIMERS];
    tmr_ctrl_t           ctrl_arr  [N_TIMERS];

    aux_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (aux_addr),
        .wr      (aux_wr),
        .hit_cnt (hit_cnt),
        .hit_ctl (hit_ctl),
        .hit_lim (hit_lim),
        .we_cnt  (we_cnt),
        .we_ctl  (we_ctl),
        .we_lim  (we_lim)
    );

    for (genvar t = 0; t < N_TIMERS; t++) begin : g_tmr
        timer_unit #(.CNT_W(CNT_W)) u_tmr (
            .clk        (clk),
            .rst_n      (rst_n),
            .cpu_halted (cpu_halted),
            .cnt_we     (we_cnt[t]),
            .ctl_we     (we_ctl[t]),
            .lim_we     (we_lim[t]),
            .wr_val     (aux_wdata[CNT_W-1:0]),
            .ctl_val    (tmr_ctrl_t'(aux_wdata[CTL_W-1:0])),
            .count_o    (count_arr[t]),
            .limit_o    (limit_arr[t]),
            .ctrl_o     (ctrl_arr[t]),
            .irq_o      (irq[t])
        );
    end

    always_comb begin
        aux_rdata = '0;
        for (int t = 0; t < N_TIMERS; t++) begin
            if (hit_cnt[t]) aux_rdata[CNT_W-1:0] = count_arr[t];
            if (hit_lim[t]) aux_rdata[CNT_W-1:0] = limit_arr[t];
            if (hit_ctl[t]) aux_rdata[CTL_W-1:0] = ctrl_arr[t];
        end
    end

    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(|{hit_cnt, hit_ctl, hit_lim}) |-> (aux_rdata == '0));

    a_r9_unmapped_write_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_wr && !(|{hit_cnt, hit_ctl, hit_lim}) && (irq != '0)) |=> ($past(irq) & ~irq) == '0);

endmodule

// File: tb/tb_limit_timer_pair.sv
`timescale 1ns/1ps
module tb_limit_timer_pair;

    localparam int W = 6;
    localparam int unsigned M = (1 << W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] aux_addr = '0;
    logic        aux_wr = 1'b0;
    logic [31:0] aux_wdata = '0;
    logic        cpu_halted = 1'b0;
    logic [31:0] aux_rdata;
    logic [1:0]  irq;

    limit_timer_pair #(.ADDR_W(12), .DATA_W(32), .CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .aux_addr(aux_addr), .aux_wr(aux_wr),
        .aux_wdata(aux_wdata), .cpu_halted(cpu_halted),
        .aux_rdata(aux_rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    int cyc = 0;

    int unsigned mcnt [2];
    int unsigned mlim [2];
    int unsigned mctl [2];
    bit          mirq [2];

    function automatic int unsigned base(input int t);
        return (t == 0) ? 32'h21 : 32'h100;
    endfunction

    function automatic bit mapped(input int unsigned a);
        for (int t = 0; t < 2; t++)
            if (a >= base(t) && a <= base(t) + 2) return 1;
        return 0;
    endfunction

    function automatic int unsigned exp_rd(input int unsigned a);
        for (int t = 0; t < 2; t++) begin
            if (a == base(t))     return mcnt[t];
            if (a == base(t) + 1) return mctl[t];
            if (a == base(t) + 2) return mlim[t];
        end
        return 0;
    endfunction

    task automatic model_update();
        for (int t = 0; t < 2; t++) begin
            bit tick, hit;
            int unsigned a;
            tick = !(mctl[t][1] && cpu_halted);
            hit  = tick && (mcnt[t] == mlim[t]);
            if (hit && mctl[t][0]) mirq[t] = 1;
            if (hit) mcnt[t] = 0;
            else if (tick) mcnt[t] = (mcnt[t] + 1) & M;
            a = aux_addr;
            if (aux_wr) begin
                if (a == base(t))     mcnt[t] = aux_wdata & M;
                if (a == base(t) + 1) begin mctl[t] = aux_wdata & 3; mirq[t] = 0; end
                if (a == base(t) + 2) mlim[t] = aux_wdata & M;
            end
        end
    endtask

    task automatic compare(input string tag);
        int unsigned e;
        e = exp_rd(aux_addr);
        vectors++;
        if (irq !== {mirq[1], mirq[0]} || aux_rdata !== e) begin
            fails++;
            $display("FAIL %s addr=%h: irq=%b rdata=%h expected irq=%b rdata=%h",
                     tag, aux_addr, irq, aux_rdata, {mirq[1], mirq[0]}, e);
        end
    endtask

    task automatic step(input int unsigned a, input bit wr, input logic [31:0] wd,
                        input bit halt, input string tag);
        aux_addr = a[11:0]; aux_wr = wr; aux_wdata = wd; cpu_halted = halt;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected completion", cyc);
            finish_run();
        end
    end

    localparam int unsigned T0C = 32'h21, T0K = 32'h22, T0L = 32'h23;
    localparam int unsigned T1C = 32'h100, T1K = 32'h101, T1L = 32'h102;

    initial begin
        for (int t = 0; t < 2; t++) begin
            mcnt[t] = 0; mlim[t] = M; mctl[t] = 0; mirq[t] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset values, read before the first active edge
        foreach (mcnt[t]) begin
            aux_addr = base(t);     #0.1 compare("R11");
            aux_addr = base(t) + 1; #0.1 compare("R11");
            aux_addr = base(t) + 2; #0.1 compare("R11");
        end

        // R2 R8: timer 1 free-running, halt ignored without gating (R6)
        for (int i = 0; i < 140; i++) step(T1C, 0, 0, i[0], "R8");

        // R3 R4: every limit with interrupts on, two intervals each
        for (int l = 0; l <= int'(M); l++) begin
            step(T0L, 1, l, 0, "R3");
            step(T0C, 1, 0, 0, "R7");
            step(T0K, 1, 1, 0, "R5");
            for (int i = 0; i < 2 * l + 4; i++) step(T0C, 0, 0, 0, "R4");
        end
        step(T0K, 1, 32'hFFFF_FFFC, 0, "R5");

        // R4: enable off, matches raise nothing
        step(T0L, 1, 3, 0, "R4");
        for (int i = 0; i < 20; i++) step(T0C, 0, 0, 0, "R4");

        // R6: halt gating on
        step(T0L, 1, 7, 0, "R6");
        step(T0K, 1, 3, 0, "R6");
        for (int i = 0; i < 40; i++) step(T0C, 0, 0, (i % 3) == 0, "R6");
        step(T0K, 1, 1, 1, "R6");
        for (int i = 0; i < 30; i++) step(T0C, 0, 0, 1, "R6");

        // R7: count write beats increment and wrap
        step(T0L, 1, M, 0, "R7");
        for (int i = 0; i < 3; i++) step(T0C, 1, 17, 0, "R7");
        step(T0C, 1, M, 0, "R7");
        for (int i = 0; i < 4; i++) step(T0C, 0, 0, 0, "R7");

        // R5: acknowledge in the same cycle as a match
        step(T0L, 1, 5, 0, "R5");
        step(T0C, 1, 5, 0, "R5");
        step(T0K, 1, 1, 0, "R5");
        for (int i = 0; i < 10; i++) step(T0C, 0, 0, 0, "R5");

        // R10: timer 1 interrupts while timer 0 is acknowledged
        step(T1L, 1, 4, 0, "R10");
        step(T1C, 1, 0, 0, "R10");
        step(T1K, 1, 1, 0, "R10");
        for (int i = 0; i < 12; i++) step(T0C, 0, 0, 0, "R10");
        step(T0K, 1, 0, 0, "R10");
        step(T1C, 0, 0, 0, "R10");

        // R1 R9: read every address, then write every unmapped one
        for (int a = 0; a < 4096; a++) step(a, 0, 0, a[1], "R9");
        for (int a = 0; a < 4096; a++)
            if (!mapped(a)) step(a, 1, 32'hFFFF_FFFF, 0, "R9");
        step(T0C, 0, 0, 0, "R1"); step(T0K, 0, 0, 0, "R1"); step(T0L, 0, 0, 0, "R1");
        step(T1C, 0, 0, 0, "R1"); step(T1K, 0, 0, 0, "R1"); step(T1L, 0, 0, 0, "R1");

        finish_run();
    end

endmodule